// File: doc/BRIEF.md
# TDM Multichannel Slot Selector

This block sits between a time-division-multiplexed serial link and a word-level data path. A frame holds up to 128 time slots. A frame-sync pulse restarts a slot counter at zero. Each word strobe marks the end of the current slot. For every slot the block checks a per-channel enable bitmap. An enabled slot produces a one-cycle pulse that carries the slot number, the slot's compand flag, the selected companding law and the companding direction. A disabled slot produces no pulse, so no word is moved. In transmit mode the serial data line is driven only during enabled slots. The rest of the time its output enable stays low, which leaves the line at its idle level.

The frame length is programmed as the slot count minus one. When the strobe of the last slot arrives, the counter wraps to zero and the frame closes. Any strobe after that, and before the next frame sync, is handled as a disabled slot. A configuration port writes two banks of 32-bit registers: one bank holds the enable bitmap and the other holds the compand-select bitmap. The companding arithmetic itself is done elsewhere. This block only raises the request.

The sequencer has three states, each with named transitions:

- **WAIT** is the state after reset.
  - **start**: a frame sync moves it to SLOTS.
- **SLOTS** is the state while the frame is open.
  - **step**: a strobe below the last slot adds one to the counter.
  - **wrap**: a strobe on the last slot sets the counter to zero and moves to DONE.
  - **resync**: a frame sync sets the counter to zero and stays in SLOTS.
- **DONE** is the state after the frame has wrapped.
  - **restart**: a frame sync moves back to SLOTS.

Top module: `tdm_slot_picker`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_wdata` into register `cfg_idx` of the bank picked by `cfg_bank` (0 = enable bitmap, 1 = compand bitmap). Bit b of register i covers channel 32*i + b, so bit 12 of register 1 covers channel 44.
- R2: After reset both bitmaps are all zero, the block is in WAIT, `cur_slot` is 0, `take_vld` is 0 and `tx_oe` is 0.
- R3: A strobe that arrives before the first frame sync produces no `take_vld`. The first frame sync puts the block in SLOTS with `cur_slot` at 0 from the next cycle on.
- R4: In SLOTS, each strobe adds one to `cur_slot`. `take_vld` is high in the cycle after a strobe exactly when the enable bit of the slot being ended is set, and `take_slot` then holds that slot number.
- R5: A strobe ending slot `slot_last` sets `cur_slot` to 0 and closes the frame. Later strobes produce no `take_vld` and leave `cur_slot` at 0 until the next frame sync.
- R6: With `take_vld`, `take_cmp` equals the compand bit of the slot. `take_law` equals `law_sel` as sampled at the strobe (0 = A-law, 1 = mu-law).
- R7: With `take_vld`, `take_expand` is 1 when `dir_tx` was 0 at the strobe (receive: expand) and 0 when it was 1 (transmit: compress).
- R8: `tx_oe` is high only when `dir_tx` is 1, the frame is open and the enable bit of `cur_slot` is set. Otherwise it is low.
- R9: A frame sync in the same cycle as a strobe first ends the slot at the current counter value, and may produce a pulse for it. The counter is then 0 and the frame is open.
- R10: `cur_slot` always shows the sequencer's current slot number as a read-only status output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bank | input | 1 | 0 = enable bitmap, 1 = compand bitmap |
| cfg_idx | input | 2 | Register index within the bank |
| cfg_wdata | input | 32 | Register write data |
| slot_last | input | 7 | Number of slots per frame minus one |
| law_sel | input | 1 | 0 = A-law, 1 = mu-law |
| dir_tx | input | 1 | 1 = transmit instance, 0 = receive |
| fsync | input | 1 | Frame-sync pulse |
| word_stb | input | 1 | End-of-slot strobe |
| cur_slot | output | 7 | Current slot number (status) |
| take_vld | output | 1 | One-cycle pulse for an enabled slot |
| take_slot | output | 7 | Slot number of the pulse |
| take_cmp | output | 1 | Slot needs companding |
| take_law | output | 1 | Companding law for the pulse |
| take_expand | output | 1 | 1 = expand, 0 = compress |
| tx_oe | output | 1 | Transmit data line output enable |

## Verification
The hardest situation to reach from the ports is a run of strobes that arrive after the counter has wrapped but before the next frame sync. Reaching it needs a short programmed frame and a sync that comes late. The stimulus therefore reprograms `slot_last` often, choosing small values, and keeps frame-sync pulses sparse compared with strobes. Directed cases add a one-slot frame, a full 128-slot frame, a sync that lands on a strobe, and a single enabled channel at bit 12 of register 1. A bench model follows the open or closed state of the frame and predicts every output.

// File: rtl/tdm_sel_pkg.sv
package tdm_sel_pkg;
    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_SLOTS = 2'd1,
        ST_DONE  = 2'd2
    } frame_st_t;
endpackage

// File: rtl/tdm_sel_bank.sv
module tdm_sel_bank #(
    parameter int SLOTS = 128,
    parameter int REG_W = 32,
    localparam int NUM_REGS = SLOTS / REG_W,
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int CNT_W = $clog2(SLOTS),
    localparam int BIT_W = $clog2(REG_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [REG_W-1:0] wdata,
    input  logic [CNT_W-1:0] rd_slot,
    output logic             rd_bit
);
    logic [NUM_REGS-1:0][REG_W-1:0] bits_q;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bits_q[g] <= '0;
            end else if (we && (idx == IDX_W'(g))) begin
                bits_q[g] <= wdata;
            end
        end
    end

    // slot number splits into register index (upper bits) and bit position
    assign rd_bit = bits_q[rd_slot[CNT_W-1:BIT_W]][rd_slot[BIT_W-1:0]];
endmodule

// File: rtl/tdm_sel_seq.sv
module tdm_sel_seq
    import tdm_sel_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    input  logic             word_stb,
    input  logic [CNT_W-1:0] slot_last,
    output frame_st_t        st,
    output logic [CNT_W-1:0] slot,
    output logic             serve,
    output logic             open
);
    frame_st_t        st_n;
    logic [CNT_W-1:0] slot_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= ST_WAIT;
            slot <= '0;
        end else begin
            st   <= st_n;
            slot <= slot_n;
        end
    end

    always_comb begin
        st_n   = st;
        slot_n = slot;
        unique case (st)
            ST_WAIT: begin
                st_n = ST_WAIT;
            end
            ST_SLOTS: begin
                if (word_stb) begin
                    if (slot == slot_last) begin   // wrap
                        slot_n = '0;
                        st_n   = ST_DONE;
                    end else begin                 // step
                        slot_n = slot + 1'b1;
                    end
                end
            end
            ST_DONE: begin
                st_n = ST_DONE;
            end
            default: begin
                st_n   = ST_WAIT;
                slot_n = '0;
            end
        endcase
        if (fsync) begin                           // start / resync / restart
            st_n   = ST_SLOTS;
            slot_n = '0;
        end
    end

    assign open  = (st == ST_SLOTS);
    assign serve = open && word_stb;
endmodule

// File: rtl/tdm_slot_picker.sv
module tdm_slot_picker
    import tdm_sel_pkg::*;
#(
    parameter int SLOTS = 128,
    parameter int REG_W = 32,
    localparam int NUM_REGS = SLOTS / REG_W,
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int CNT_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_bank,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic [CNT_W-1:0] slot_last,
    input  logic             law_sel,
    input  logic             dir_tx,
    input  logic             fsync,
    input  logic             word_stb,
    output logic [CNT_W-1:0] cur_slot,
    output logic             take_vld,
    output logic [CNT_W-1:0] take_slot,
    output logic             take_cmp,
    output logic             take_law,
    output logic             take_expand,
    output logic             tx_oe
);
    localparam int NUM_BANKS = 2;

    frame_st_t      frame_st;
    logic           serve;
    logic           open;
    logic [NUM_BANKS-1:0] bank_bit;

    tdm_sel_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync     (fsync),
        .word_stb  (word_stb),
        .slot_last (slot_last),
        .st        (frame_st),
        .slot      (cur_slot),
        .serve     (serve),
        .open      (open)
    );

    // bank 0: enable bitmap, bank 1: compand bitmap
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        tdm_sel_bank #(.SLOTS(SLOTS), .REG_W(REG_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (cfg_we && (cfg_bank == 1'(b))),
            .idx     (cfg_idx),
            .wdata   (cfg_wdata),
            .rd_slot (cur_slot),
            .rd_bit  (bank_bit[b])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            take_vld    <= 1'b0;
            take_slot   <= '0;
            take_cmp    <= 1'b0;
            take_law    <= 1'b0;
            take_expand <= 1'b0;
        end else begin
            take_vld <= serve && bank_bit[0];
            if (serve) begin
                take_slot   <= cur_slot;
                take_cmp    <= bank_bit[1];
                take_law    <= law_sel;
                take_expand <= !dir_tx;
            end
        end
    end

    assign tx_oe = dir_tx && open && bank_bit[0];
endmodule

// File: rtl/tdm_slot_picker_chk.sv
module tdm_slot_picker_chk
    import tdm_sel_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fsync,
    input logic             word_stb,
    input logic [CNT_W-1:0] slot_last,
    input logic             dir_tx,
    input frame_st_t        frame_st,
    input logic [CNT_W-1:0] cur_slot,
    input logic             take_vld,
    input logic [CNT_W-1:0] take_slot,
    input logic             take_expand,
    input logic             tx_oe
);
    AST_SYNC_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> (frame_st == ST_SLOTS) && (cur_slot == '0));  // R3
    AST_PULSE_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        take_vld |-> ($past(word_stb) && ($past(frame_st) == ST_SLOTS)));  // R4
    AST_PULSE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        take_vld |-> (take_slot == $past(cur_slot)));  // R4
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb && !fsync && (frame_st == ST_SLOTS) && (cur_slot != slot_last))
        |=> (cur_slot == CNT_W'($past(cur_slot) + 1'b1)));  // R4
    AST_WRAP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb && !fsync && (frame_st == ST_SLOTS) && (cur_slot == slot_last))
        |=> ((cur_slot == '0) && (frame_st == ST_DONE)));  // R5
    AST_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        take_vld |-> (take_expand == !$past(dir_tx)));  // R7
    AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_tx || (frame_st != ST_SLOTS)) |-> !tx_oe);  // R8
endmodule

bind tdm_slot_picker tdm_slot_picker_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fsync       (fsync),
    .word_stb    (word_stb),
    .slot_last   (slot_last),
    .dir_tx      (dir_tx),
    .frame_st    (frame_st),
    .cur_slot    (cur_slot),
    .take_vld    (take_vld),
    .take_slot   (take_slot),
    .take_expand (take_expand),
    .tx_oe       (tx_oe)
);

// File: tb/tdm_slot_picker_bench.sv
`timescale 1ns/1ps
module tdm_slot_picker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_bank = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [6:0]  slot_last = 7'd127;
    logic        law_sel = 1'b0;
    logic        dir_tx = 1'b0;
    logic        fsync = 1'b0;
    logic        word_stb = 1'b0;
    logic [6:0]  cur_slot;
    logic        take_vld;
    logic [6:0]  take_slot;
    logic        take_cmp;
    logic        take_law;
    logic        take_expand;
    logic        tx_oe;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    bit en_m [128];
    bit cp_m [128];
    int cnt_m = 0;
    bit open_m = 1'b0;

    always #2 clk = ~clk;

    tdm_slot_picker u_tdm_slot_picker (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .slot_last(slot_last),
        .law_sel(law_sel), .dir_tx(dir_tx), .fsync(fsync), .word_stb(word_stb),
        .cur_slot(cur_slot), .take_vld(take_vld), .take_slot(take_slot),
        .take_cmp(take_cmp), .take_law(take_law), .take_expand(take_expand),
        .tx_oe(tx_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_oe();
        return dir_tx && open_m && en_m[cnt_m];
    endfunction

    task automatic cfg_write(input bit bank, input int idx, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_bank = bank; cfg_idx = 2'(idx); cfg_wdata = data;
        for (int b = 0; b < 32; b++) begin
            if (bank) cp_m[32*idx + b] = data[b];
            else      en_m[32*idx + b] = data[b];
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic slot_step(input bit fs, input bit stb, input string tag);
        bit e_vld; int e_slot; bit e_cmp; bit e_law; bit e_exp;
        @(negedge clk);
        fsync = fs; word_stb = stb;
        e_vld = stb && open_m && en_m[cnt_m];
        e_slot = cnt_m; e_cmp = cp_m[cnt_m]; e_law = law_sel; e_exp = !dir_tx;
        if (stb && open_m) begin
            if (cnt_m == int'(slot_last)) begin cnt_m = 0; open_m = 1'b0; end
            else cnt_m++;
        end
        if (fs) begin cnt_m = 0; open_m = 1'b1; end
        @(posedge clk); #1;
        fsync = 1'b0; word_stb = 1'b0;
        check(take_vld == e_vld, {tag, " R4 take_vld"}, int'(take_vld), int'(e_vld));
        if (e_vld) begin
            check(int'(take_slot) == e_slot, {tag, " R4 take_slot"}, int'(take_slot), e_slot);
            check(take_cmp == e_cmp, {tag, " R6 take_cmp"}, int'(take_cmp), int'(e_cmp));
            check(take_law == e_law, {tag, " R6 take_law"}, int'(take_law), int'(e_law));
            check(take_expand == e_exp, {tag, " R7 take_expand"}, int'(take_expand), int'(e_exp));
        end
        check(int'(cur_slot) == cnt_m, {tag, " R10 cur_slot"}, int'(cur_slot), cnt_m);
        check(tx_oe == exp_oe(), {tag, " R8 tx_oe"}, int'(tx_oe), int'(exp_oe()));
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        check(cur_slot == 0, "R2 reset cur_slot", int'(cur_slot), 0);
        check(take_vld == 0, "R2 reset take_vld", int'(take_vld), 0);
        dir_tx = 1'b1;
        #1;
        check(tx_oe == 0, "R2 reset tx_oe", int'(tx_oe), 0);
        @(negedge clk); rst_n = 1'b1;

        // R2: bitmaps cleared by reset, so an open frame yields no pulse
        slot_step(1, 0, "R2");
        slot_step(0, 1, "R2");
        slot_step(0, 1, "R2");

        // R3: strobes before the first sync (after a fresh reset)
        @(negedge clk); rst_n = 1'b0; cnt_m = 0; open_m = 0;
        foreach (en_m[i]) begin en_m[i] = 0; cp_m[i] = 0; end
        @(negedge clk); rst_n = 1'b1;
        for (int r = 0; r < 4; r++) cfg_write(0, r, 32'hFFFF_FFFF);
        for (int k = 0; k < 3; k++) slot_step(0, 1, "R3");
        slot_step(1, 0, "R3");

        // R1: only bit 12 of register 1 -> channel 44
        for (int r = 0; r < 4; r++) cfg_write(0, r, (r == 1) ? 32'h0000_1000 : 32'h0);
        cfg_write(1, 1, 32'h0000_1000);
        slot_last = 7'd127; law_sel = 1'b1; dir_tx = 1'b0;
        slot_step(1, 0, "R1");
        for (int k = 0; k < 46; k++) slot_step(0, 1, "R1");

        // R5: one-slot frame, later strobes ignored
        for (int r = 0; r < 4; r++) cfg_write(0, r, 32'hFFFF_FFFF);
        slot_last = 7'd0; dir_tx = 1'b1;
        slot_step(1, 0, "R5");
        for (int k = 0; k < 4; k++) slot_step(0, 1, "R5");

        // R9: sync and strobe together
        slot_last = 7'd5;
        slot_step(1, 0, "R9");
        slot_step(0, 1, "R9");
        slot_step(1, 1, "R9");
        slot_step(0, 1, "R9");

        // full 128-slot frame with wrap, R5
        slot_last = 7'd127;
        slot_step(1, 0, "R5");
        for (int k = 0; k < 130; k++) slot_step(0, 1, "R5");

        // random phase
        for (int it = 0; it < 4000; it++) begin
            if (it % 150 == 0) begin
                for (int r = 0; r < 4; r++) cfg_write(0, r, $urandom);
                for (int r = 0; r < 4; r++) cfg_write(1, r, $urandom);
                slot_last = ($urandom_range(0, 1) != 0) ? 7'($urandom_range(0, 9))
                                                         : 7'($urandom_range(0, 127));
            end
            if ($urandom_range(0, 15) == 0) begin
                law_sel = 1'($urandom);
                dir_tx = 1'($urandom);
            end
            slot_step($urandom_range(0, 39) == 0, $urandom_range(0, 1) == 1, "RND");
        end
        summary();
    end
endmodule